// File: doc/BRIEF.md
# Two-Street Intersection Light Controller

This block sequences the signal heads at a crossing of two streets, named A and B, and also lights a pedestrian walk lamp. It is a Moore machine. The lamps depend only on the current phase, and every phase sets all of them. The right of way alternates between the streets. Each green is followed by a yellow, and then by a short all-red gap before the other street gets green. A pedestrian request is held until it can be served. A vehicle sensor on each street can stretch that street's green up to a ceiling.

All durations are counted in clock cycles by an internal counter. Each duration is set by a parameter: `GREEN_MIN`, `EXT_CYCLES`, `GREEN_MAX`, `YELLOW_CYCLES`, `ALL_RED_CYCLES` and `WALK_CYCLES`. The inputs are assumed to be synchronous to `clk` already. The lamp outputs are registers loaded from the next phase, so they cannot glitch while the phase changes.

Top module: `xing_light_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, both streets show red (code 3'b100) and `walk_lamp` is 0. No walk request is pending after reset, so the first all-red gap leads straight to street A green.
- R2: Each street's lamp steps only green (3'b001), then yellow (3'b010), then red (3'b100). Street A's turn is followed by street B's turn, and B's turn is followed by A's.
- R3: Between the end of one street's yellow and the start of the other street's green or walk phase, both streets show red for exactly `ALL_RED_CYCLES` cycles.
- R4: With its own sensor low, a street's green lasts exactly `GREEN_MIN` cycles.
- R5: If a street's own sensor is high in the last cycle of its current green window, the green is lengthened by `EXT_CYCLES`. The total green never exceeds `GREEN_MAX`, and the last extension is shortened to fit under that cap.
- R6: Yellow lasts exactly `YELLOW_CYCLES` cycles, whatever the sensors do.
- R7: A one-cycle pulse on `walk_req` sets a pending flag. The next all-red gap to finish is followed by `WALK_CYCLES` cycles with both streets red and `walk_lamp` at 1. After that, the green that was due is given.
- R8: The pending flag clears when the walk phase is entered. Several requests that arrive before service produce a single walk phase. A request that arrives in the same cycle the walk phase is entered is absorbed by that phase.
- R9: At no time do both streets show a non-red lamp. Each street's lamp code always has exactly one bit set.
- R10: The sensor of the street that is currently red has no effect on the running green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| walk_req | input | 1 | Pedestrian request pulse |
| sense_a | input | 1 | Vehicle waiting on street A |
| sense_b | input | 1 | Vehicle waiting on street B |
| lamp_a | output | 3 | Street A lamp, one-hot {red, yellow, green} |
| lamp_b | output | 3 | Street B lamp, one-hot {red, yellow, green} |
| walk_lamp | output | 1 | Pedestrian walk indication |

## Verification
Every lamp is a direct function of the phase, so a wrong phase register shows at the ports on the very next clock edge, as a lamp code that differs from the expected one. A wrong cycle counter or green limit is harder to see. It only shows when a phase ends early or late, which can be up to `GREEN_MAX` cycles after the fault. A stuck or lost pending flag only shows at the next all-red gap, as a missing or extra walk phase. For these reasons the lamps are compared with a behavioural model on every cycle, over runs long enough to cross many phase boundaries.

// File: rtl/xing_pkg.sv
package xing_pkg;

    typedef enum logic [2:0] {
        PH_CLR_A = 3'd0,   // all red, street A is next
        PH_GRN_A = 3'd1,
        PH_YEL_A = 3'd2,
        PH_CLR_B = 3'd3,   // all red, street B is next
        PH_GRN_B = 3'd4,
        PH_YEL_B = 3'd5,
        PH_WLK_A = 3'd6,   // walk phase, street A is next
        PH_WLK_B = 3'd7    // walk phase, street B is next
    } phase_e;

    localparam logic [2:0] LAMP_GRN = 3'b001;
    localparam logic [2:0] LAMP_YEL = 3'b010;
    localparam logic [2:0] LAMP_RED = 3'b100;

    typedef struct packed {
        phase_e     phase;
        logic [2:0] lamp_a;
        logic [2:0] lamp_b;
        logic       walk;
    } ctrl_s;

    function automatic logic [2:0] head_a(phase_e p);
        case (p)
            PH_GRN_A: head_a = LAMP_GRN;
            PH_YEL_A: head_a = LAMP_YEL;
            default:  head_a = LAMP_RED;
        endcase
    endfunction

    function automatic logic [2:0] head_b(phase_e p);
        case (p)
            PH_GRN_B: head_b = LAMP_GRN;
            PH_YEL_B: head_b = LAMP_YEL;
            default:  head_b = LAMP_RED;
        endcase
    endfunction

endpackage

// File: rtl/xing_cycle_timer.sv
module xing_cycle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = restart ? '0 : count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/xing_green_window.sv
module xing_green_window #(
    parameter int CNT_W      = 5,
    parameter int GREEN_MIN  = 8,
    parameter int EXT_CYCLES = 4,
    parameter int GREEN_MAX  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             grow,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W:0]   MAX_W = (CNT_W+1)'(GREEN_MAX);
    localparam logic [CNT_W:0]   EXT_W = (CNT_W+1)'(EXT_CYCLES);
    localparam logic [CNT_W-1:0] MIN_N = CNT_W'(GREEN_MIN);

    logic [CNT_W-1:0] limit_d, limit_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, limit_q} + EXT_W;
        if (load)      limit_d = MIN_N;
        else if (grow) limit_d = (sum > MAX_W) ? MAX_W[CNT_W-1:0] : sum[CNT_W-1:0];
        else           limit_d = limit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) limit_q <= MIN_N;
        else     limit_q <= limit_d;
    end

    assign limit = limit_q;
endmodule

// File: rtl/xing_walk_flag.sv
module xing_walk_flag (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic consume,
    output logic pending
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q | req) & ~consume;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    assign pending = pend_q;
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
    import xing_pkg::*;
#(
    parameter int GREEN_MIN      = 8,
    parameter int EXT_CYCLES     = 4,
    parameter int GREEN_MAX      = 20,
    parameter int YELLOW_CYCLES  = 3,
    parameter int ALL_RED_CYCLES = 2,
    parameter int WALK_CYCLES    = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       walk_req,
    input  logic       sense_a,
    input  logic       sense_b,
    output logic [2:0] lamp_a,
    output logic [2:0] lamp_b,
    output logic       walk_lamp
);
    localparam int M1    = (GREEN_MAX > YELLOW_CYCLES) ? GREEN_MAX : YELLOW_CYCLES;
    localparam int M2    = (ALL_RED_CYCLES > WALK_CYCLES) ? ALL_RED_CYCLES : WALK_CYCLES;
    localparam int MAXD  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = $clog2(MAXD + 1);

    localparam logic [CNT_W-1:0] YEL_LAST = CNT_W'(YELLOW_CYCLES - 1);
    localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(ALL_RED_CYCLES - 1);
    localparam logic [CNT_W-1:0] WLK_LAST = CNT_W'(WALK_CYCLES - 1);
    localparam logic [CNT_W-1:0] MAX_N    = CNT_W'(GREEN_MAX);

    ctrl_s            ctrl_d, ctrl_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             walk_pending;
    logic             grow, restart, load, consume;
    logic             green_end;

    xing_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .count(cnt)
    );

    xing_green_window #(
        .CNT_W(CNT_W), .GREEN_MIN(GREEN_MIN),
        .EXT_CYCLES(EXT_CYCLES), .GREEN_MAX(GREEN_MAX)
    ) u_window (
        .clk(clk), .rst(rst), .load(load), .grow(grow), .limit(lim)
    );

    xing_walk_flag u_flag (
        .clk(clk), .rst(rst), .req(walk_req), .consume(consume), .pending(walk_pending)
    );

    always_comb begin
        ctrl_d       = ctrl_q;
        grow         = 1'b0;
        green_end    = (cnt == lim - CNT_W'(1));
        case (ctrl_q.phase)
            PH_CLR_A: if (cnt == CLR_LAST) ctrl_d.phase = walk_pending ? PH_WLK_A : PH_GRN_A;
            PH_CLR_B: if (cnt == CLR_LAST) ctrl_d.phase = walk_pending ? PH_WLK_B : PH_GRN_B;
            PH_WLK_A: if (cnt == WLK_LAST) ctrl_d.phase = PH_GRN_A;
            PH_WLK_B: if (cnt == WLK_LAST) ctrl_d.phase = PH_GRN_B;
            PH_GRN_A: if (green_end) begin
                if (sense_a && lim < MAX_N) grow = 1'b1;
                else                        ctrl_d.phase = PH_YEL_A;
            end
            PH_GRN_B: if (green_end) begin
                if (sense_b && lim < MAX_N) grow = 1'b1;
                else                        ctrl_d.phase = PH_YEL_B;
            end
            PH_YEL_A: if (cnt == YEL_LAST) ctrl_d.phase = PH_CLR_B;
            PH_YEL_B: if (cnt == YEL_LAST) ctrl_d.phase = PH_CLR_A;
            default:  ctrl_d.phase = PH_CLR_A;
        endcase
        restart       = (ctrl_d.phase != ctrl_q.phase);
        load          = restart && (ctrl_d.phase == PH_GRN_A || ctrl_d.phase == PH_GRN_B);
        consume       = restart && (ctrl_d.phase == PH_WLK_A || ctrl_d.phase == PH_WLK_B);
        ctrl_d.lamp_a = head_a(ctrl_d.phase);
        ctrl_d.lamp_b = head_b(ctrl_d.phase);
        ctrl_d.walk   = (ctrl_d.phase == PH_WLK_A || ctrl_d.phase == PH_WLK_B);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.phase  <= PH_CLR_A;
            ctrl_q.lamp_a <= LAMP_RED;
            ctrl_q.lamp_b <= LAMP_RED;
            ctrl_q.walk   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign lamp_a    = ctrl_q.lamp_a;
    assign lamp_b    = ctrl_q.lamp_b;
    assign walk_lamp = ctrl_q.walk;
endmodule

// File: rtl/xing_light_ctrl_chk.sv
module xing_light_ctrl_chk #(
    parameter int YELLOW_CYCLES = 3
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] lamp_a,
    input logic [2:0] lamp_b,
    input logic       walk_lamp,
    input logic       pending
);
    localparam int YW = $clog2(YELLOW_CYCLES + 2);
    logic [YW-1:0] yel_run_q;

    always_ff @(posedge clk) begin
        if (rst)            yel_run_q <= '0;
        else if (lamp_a[1]) yel_run_q <= yel_run_q + YW'(1);
        else                yel_run_q <= '0;
    end

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(lamp_a != 3'b100 && lamp_b != 3'b100));

    assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(lamp_a) == 1 && $countones(lamp_b) == 1);

    assert_walk_all_red_R7: assert property (@(posedge clk) disable iff (rst)
        walk_lamp |-> (lamp_a == 3'b100 && lamp_b == 3'b100));

    assert_green_to_yellow_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(lamp_a[0]) |-> lamp_a[1]);

    assert_yellow_to_red_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(lamp_a[1]) |-> lamp_a[2]);

    assert_flag_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(walk_lamp) |-> !pending);

    assert_yellow_length_R6: assert property (@(posedge clk) disable iff (rst)
        (!lamp_a[1] && yel_run_q != '0) |-> yel_run_q == YW'(YELLOW_CYCLES));
endmodule

bind xing_light_ctrl xing_light_ctrl_chk #(.YELLOW_CYCLES(YELLOW_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .lamp_a(lamp_a), .lamp_b(lamp_b),
    .walk_lamp(walk_lamp), .pending(walk_pending)
);

// File: tb/xing_light_ctrl_bench.sv
module xing_light_ctrl_bench;
    localparam int GMIN = 8, GEXT = 4, GMAX = 20, YEL = 3, CLR = 2, WLK = 6;

    logic clk = 1'b0;
    logic rst = 1'b1, walk_req = 1'b0, sense_a = 1'b0, sense_b = 1'b0;
    logic [2:0] lamp_a, lamp_b;
    logic walk_lamp;

    always #5 clk = ~clk;

    xing_light_ctrl #(
        .GREEN_MIN(GMIN), .EXT_CYCLES(GEXT), .GREEN_MAX(GMAX),
        .YELLOW_CYCLES(YEL), .ALL_RED_CYCLES(CLR), .WALK_CYCLES(WLK)
    ) u_xing_light_ctrl (
        .clk(clk), .rst(rst), .walk_req(walk_req), .sense_a(sense_a), .sense_b(sense_b),
        .lamp_a(lamp_a), .lamp_b(lamp_b), .walk_lamp(walk_lamp)
    );

    // model phases: red gaps, greens, yellows, walks
    localparam int GAP_A = 0, GO_A = 1, AMB_A = 2, GAP_B = 3, GO_B = 4, AMB_B = 5, PED_A = 6, PED_B = 7;
    int m_ph, m_left, m_granted, m_changed;
    bit m_req;
    int checks = 0, fails = 0, cyc = 0;
    int seed = 12345;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int lamp_for(input int ph, input bit street_b);
        if (!street_b && ph == GO_A) return 1;
        if (!street_b && ph == AMB_A) return 2;
        if (street_b && ph == GO_B) return 1;
        if (street_b && ph == AMB_B) return 2;
        return 4;
    endfunction

    task automatic model_step(input bit r, input bit w, input bit sa, input bit sb);
        int old;
        bit nreq;
        int add;
        old = m_ph;
        if (r) begin
            m_ph = GAP_A; m_left = CLR; m_req = 0; m_granted = GMIN;
        end else begin
            nreq = m_req | w;
            if (m_left > 1) m_left--;
            else begin
                if (m_ph == GAP_A || m_ph == GAP_B) begin
                    if (m_req) begin
                        m_ph = (m_ph == GAP_A) ? PED_A : PED_B; m_left = WLK; nreq = 0;
                    end else begin
                        m_ph = (m_ph == GAP_A) ? GO_A : GO_B; m_left = GMIN; m_granted = GMIN;
                    end
                end else if (m_ph == PED_A || m_ph == PED_B) begin
                    m_ph = (m_ph == PED_A) ? GO_A : GO_B; m_left = GMIN; m_granted = GMIN;
                end else if (m_ph == GO_A || m_ph == GO_B) begin
                    if (((m_ph == GO_A) ? sa : sb) && m_granted < GMAX) begin
                        add = (GMAX - m_granted < GEXT) ? GMAX - m_granted : GEXT;
                        m_granted += add; m_left = add;
                    end else begin
                        m_ph = (m_ph == GO_A) ? AMB_A : AMB_B; m_left = YEL;
                    end
                end else if (m_ph == AMB_A) begin
                    m_ph = GAP_B; m_left = CLR;
                end else begin
                    m_ph = GAP_A; m_left = CLR;
                end
            end
            m_req = nreq;
        end
        m_changed = (old != m_ph);
    endtask

    task automatic step(input bit r, input bit w, input bit sa, input bit sb);
        string tag;
        int ea, eb, ew;
        rst = r; walk_req = w; sense_a = sa; sense_b = sb;
        @(posedge clk);
        model_step(r, w, sa, sb);
        @(negedge clk);
        ea = lamp_for(m_ph, 0); eb = lamp_for(m_ph, 1);
        ew = (m_ph == PED_A || m_ph == PED_B) ? 1 : 0;
        if (r) tag = "R1";
        else if (m_changed != 0) tag = "R2";
        else if (m_ph == GAP_A || m_ph == GAP_B) tag = "R3";
        else if (m_ph == AMB_A || m_ph == AMB_B) tag = "R6";
        else if (m_ph == PED_A || m_ph == PED_B) tag = "R7";
        else if (m_granted > GMIN) tag = "R5";
        else if ((m_ph == GO_A && sb) || (m_ph == GO_B && sa)) tag = "R10";
        else tag = "R4";
        check(int'(lamp_a) == ea, tag, "lamp_a", int'(lamp_a), ea);
        check(int'(lamp_b) == eb, tag, "lamp_b", int'(lamp_b), eb);
        check(int'(walk_lamp) == ew, tag, "walk_lamp", int'(walk_lamp), ew);
        check(!(lamp_a != 3'b100 && lamp_b != 3'b100) && $countones(lamp_a) == 1
              && $countones(lamp_b) == 1, "R9", "lamp pair", int'({lamp_a, lamp_b}), 0);
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int rises;
        bit prev_w;
        bit ra, rb;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);   // R1 reset state
        for (int i = 0; i < 70; i++) step(0, 0, 0, 0);  // R4, R3, R2 idle cycle
        for (int i = 0; i < 100; i++) step(0, 0, 1, 0); // R5 cap on street A
        for (int i = 0; i < 60; i++) step(0, 0, 0, 1);  // R10 / R5 on street B
        for (int i = 0; i < 30; i++) step(0, 0, 1, 1);  // R6 yellow ignores sensors

        // R8: burst of requests gives exactly one walk phase
        for (int i = 0; i < 60 && lamp_a == 3'b001; i++) step(0, 0, 0, 0);
        for (int i = 0; i < 60 && lamp_a != 3'b001; i++) step(0, 0, 0, 0);
        rises = 0; prev_w = walk_lamp;
        for (int i = 0; i < 40; i++) begin
            step(0, (i == 0 || i == 2 || i == 4), 0, 0);
            if (walk_lamp && !prev_w) rises++;
            prev_w = walk_lamp;
        end
        check(rises == 1, "R8", "walk phases after burst", rises, 1);

        // mixed traffic and requests, R7
        ra = 0; rb = 0;
        for (int i = 0; i < 400; i++) begin
            if ((rnd() & 7) == 0) ra = ~ra;
            if ((rnd() & 7) == 0) rb = ~rb;
            step(0, (rnd() & 15) == 0, ra, rb);
        end

        // reset in mid-operation, R1
        step(1, 1, 1, 1);
        step(1, 0, 0, 0);
        for (int i = 0; i < 60; i++) step(0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule